// File: doc/BRIEF.md
# Interval-Based Unfairness Evaluator

This block sits beside the cores of a multi-core memory system and judges fairness once per fixed-length interval. Each core supplies a fixed-point slowdown estimate and a software weight. Their product is the core's weighted slowdown, so software can raise a thread's priority through its weight. During the interval the block counts interference events in an internal matrix. An event is tagged with a victim core and a culprit core. The counters saturate.

At every interval boundary the block takes a snapshot of the inputs and of the counter matrix, and then clears the live counters. From the snapshot it names the core with the largest weighted slowdown (the slowest core). It also names the core that delayed that core most (the interferer). It computes an unfairness figure, which is the ratio of the largest to the smallest weighted slowdown, and compares it with a software target. A fixed number of cycles later it emits a one-cycle decision. The decision carries both core IDs and the unfairness value. When the target is exceeded it also raises a throttle-down flag for the interferer and a throttle-up flag for the slowest core; otherwise both flags stay low.

Top module: `uf_eval`

## Requirements
- R1: The weighted slowdown of core i is slowdown_in[i*SD_W +: SD_W] times weight_in[i*WT_W +: WT_W], unsigned. dec_slow names the core with the largest weighted slowdown; on a tie the lowest index wins.
- R2: dec_intf names the core j, with j different from dec_slow, whose interference count against victim dec_slow is largest. On a tie, including a row that is all zero, the lowest such index wins.
- R3: dec_unfair equals floor(256 * max / min) over the weighted slowdowns, in unsigned Q8.8 with UF_W bits. It saturates to all ones when the result does not fit or when the minimum is zero.
- R4: dec_down and dec_up are both 1 when dec_unfair is strictly greater than the target, and both 0 otherwise, including when the two are equal.
- R5: Interval boundaries fall on every INTERVAL_LEN-th clock edge after reset is released. dec_valid is high for exactly one cycle, after the edge that comes LAT = SD_W+WT_W+11 edges after a boundary edge. It is low at all other times.
- R6: An event (ev_valid with ev_victim and ev_culprit) adds one to counter [victim][culprit]. Counters saturate at 2^CNT_W-1. An event whose victim equals its culprit is not counted.
- R7: slowdown_in, weight_in and target_in are sampled only on the boundary edge. Values they take at other times do not change the decision.
- R8: The counters clear on the boundary edge, after their values are captured for the decision. An event presented on the boundary edge counts toward the new interval.
- R9: While reset is high, dec_valid, dec_down, dec_up, dec_slow, dec_intf and dec_unfair are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slowdown_in | input | N_CORES*SD_W | Per-core slowdown estimates, core i at bits i*SD_W |
| weight_in | input | N_CORES*WT_W | Per-core software weights |
| target_in | input | UF_W | Unfairness target, Q8.8 |
| ev_valid | input | 1 | Interference event this cycle |
| ev_victim | input | ID_W | Core that was delayed |
| ev_culprit | input | ID_W | Core that caused the delay |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_slow | output | ID_W | Slowest core |
| dec_intf | output | ID_W | Chief interferer of the slowest core |
| dec_down | output | 1 | Throttle interferer down |
| dec_up | output | 1 | Throttle slowest core up |
| dec_unfair | output | UF_W | Unfairness figure, Q8.8 |

## Verification
Two things can land on the same boundary edge: the clearing of the interference matrix, and a new interference event that must be counted. The bench provokes this with an interval that has no events except one, a victim/culprit pair presented exactly on the boundary edge. The previous interval's decision must show that pair absent, and the following interval's decision must name that culprit as the interferer. The bench also checks that the inputs it changes while a decision is still in flight do not leak into that decision.

// File: rtl/uf_pkg.sv
package uf_pkg;
  // Fractional bits of the unfairness ratio (Q8.8 style)
  localparam int FRAC_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RANK,
    ST_PREP,
    ST_DIV
  } uf_state_e;
endpackage

// File: rtl/uf_intf_matrix.sv
// Live interference counters plus a snapshot captured at each boundary.
module uf_intf_matrix #(
  parameter int N     = 4,
  parameter int CNT_W = 8,
  parameter int ID_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   ev_valid,
  input  logic [ID_W-1:0]        ev_victim,
  input  logic [ID_W-1:0]        ev_culprit,
  output logic [N*N*CNT_W-1:0]   snap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar v = 0; v < N; v++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (v == c) begin : g_diag
        // a core is never its own interferer: no storage at all
        assign snap[(v*N+c)*CNT_W +: CNT_W] = '0;
      end else begin : g_cell
        logic [CNT_W-1:0] live_q;
        logic [CNT_W-1:0] snap_q;
        logic             hit;

        assign hit = ev_valid && (ev_victim == ID_W'(v)) && (ev_culprit == ID_W'(c));

        always_ff @(posedge clk) begin
          if (rst) begin
            live_q <= '0;
            snap_q <= '0;
          end else if (clr) begin
            snap_q <= live_q;
            live_q <= hit ? CNT_W'(1) : '0;
          end else if (hit && live_q != CNT_MAX) begin
            live_q <= live_q + 1'b1;
          end
        end

        assign snap[(v*N+c)*CNT_W +: CNT_W] = snap_q;
      end
    end
  end
endmodule

// File: rtl/uf_argmax.sv
// Index of the largest entry, lowest index on ties, optional exclusion.
module uf_argmax #(
  parameter int N    = 4,
  parameter int W    = 16,
  parameter int ID_W = 2
) (
  input  logic [N*W-1:0]  vals,
  input  logic            excl_en,
  input  logic [ID_W-1:0] excl_idx,
  output logic [ID_W-1:0] max_idx
);
  logic [W-1:0]    best;
  logic [ID_W-1:0] idx;
  logic            found;

  always_comb begin
    best  = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!(excl_en && excl_idx == ID_W'(i))) begin
        if (!found || vals[i*W +: W] > best) begin
          best  = vals[i*W +: W];
          idx   = ID_W'(i);
          found = 1'b1;
        end
      end
    end
    max_idx = idx;
  end
endmodule

// File: rtl/uf_divider.sv
// Restoring divider, one quotient bit per cycle, fixed NUM_W-cycle latency.
module uf_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CW = $clog2(NUM_W);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             take;
  logic [DEN_W-1:0] rem_nx;

  always_comb begin
    trial  = {rem_q, quo[NUM_W-1]};
    take   = (trial >= {1'b0, den_q});
    diff   = trial - {1'b0, den_q};
    rem_nx = take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo   <= num;
        den_q <= den;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_nx;
        quo   <= {quo[NUM_W-2:0], take};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NUM_W-1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uf_eval.sv
module uf_eval
  import uf_pkg::*;
#(
  parameter int N_CORES      = 4,
  parameter int SD_W         = 16,
  parameter int WT_W         = 8,
  parameter int CNT_W        = 8,
  parameter int UF_W         = 16,
  parameter int INTERVAL_LEN = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES*SD_W-1:0]   slowdown_in,
  input  logic [N_CORES*WT_W-1:0]   weight_in,
  input  logic [UF_W-1:0]           target_in,
  input  logic                      ev_valid,
  input  logic [$clog2(N_CORES)-1:0] ev_victim,
  input  logic [$clog2(N_CORES)-1:0] ev_culprit,
  output logic                      dec_valid,
  output logic [$clog2(N_CORES)-1:0] dec_slow,
  output logic [$clog2(N_CORES)-1:0] dec_intf,
  output logic                      dec_down,
  output logic                      dec_up,
  output logic [UF_W-1:0]           dec_unfair
);
  localparam int ID_W  = $clog2(N_CORES);
  localparam int WP_W  = SD_W + WT_W;
  localparam int NUM_W = WP_W + FRAC_BITS;
  localparam int LAT   = NUM_W + 3;
  localparam int IV_W  = $clog2(INTERVAL_LEN);
  localparam int ROW_W = N_CORES * CNT_W;

  // interval timer
  logic [IV_W-1:0] iv_q;
  logic            tick;

  assign tick = (iv_q == IV_W'(INTERVAL_LEN-1));

  always_ff @(posedge clk) begin
    if (rst) iv_q <= '0;
    else     iv_q <= tick ? '0 : iv_q + 1'b1;
  end

  // weighted slowdowns, captured at the boundary
  logic [N_CORES*WP_W-1:0] wp_d;
  logic [N_CORES*WP_W-1:0] wp_q;
  logic [UF_W-1:0]         tgt_q;

  for (genvar i = 0; i < N_CORES; i++) begin : g_wp
    assign wp_d[i*WP_W +: WP_W] = WP_W'(slowdown_in[i*SD_W +: SD_W]) *
                                  WP_W'(weight_in[i*WT_W +: WT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      tgt_q <= '0;
    end else if (tick) begin
      wp_q  <= wp_d;
      tgt_q <= target_in;
    end
  end

  // interference matrix
  logic [N_CORES*N_CORES*CNT_W-1:0] snap;

  uf_intf_matrix #(.N(N_CORES), .CNT_W(CNT_W), .ID_W(ID_W)) u_mat (
    .clk       (clk),
    .rst       (rst),
    .clr       (tick),
    .ev_valid  (ev_valid),
    .ev_victim (ev_victim),
    .ev_culprit(ev_culprit),
    .snap      (snap)
  );

  // ranking of weighted slowdowns
  logic [ID_W-1:0] top_idx;
  logic [WP_W-1:0] top_val;
  logic [WP_W-1:0] low_val;

  uf_argmax #(.N(N_CORES), .W(WP_W), .ID_W(ID_W)) u_rank (
    .vals    (wp_q),
    .excl_en (1'b0),
    .excl_idx('0),
    .max_idx (top_idx)
  );

  always_comb begin
    top_val = '0;
    low_val = wp_q[0 +: WP_W];
    for (int i = 0; i < N_CORES; i++) begin
      if (top_idx == ID_W'(i)) top_val = wp_q[i*WP_W +: WP_W];
      if (wp_q[i*WP_W +: WP_W] < low_val) low_val = wp_q[i*WP_W +: WP_W];
    end
  end

  // interferer of the slowest core
  logic [ID_W-1:0]  slow_q;
  logic [ROW_W-1:0] row;
  logic [ID_W-1:0]  pick_idx;

  always_comb begin
    row = '0;
    for (int v = 0; v < N_CORES; v++) begin
      if (slow_q == ID_W'(v)) row = snap[v*ROW_W +: ROW_W];
    end
  end

  uf_argmax #(.N(N_CORES), .W(CNT_W), .ID_W(ID_W)) u_pick (
    .vals    (row),
    .excl_en (1'b1),
    .excl_idx(slow_q),
    .max_idx (pick_idx)
  );

  // ratio divider
  uf_state_e        state_q;
  logic [WP_W-1:0]  max_q;
  logic [WP_W-1:0]  min_q;
  logic [ID_W-1:0]  intf_q;
  logic [NUM_W-1:0] quo;
  logic             div_done;
  logic             div_start;
  logic [UF_W-1:0]  unf_sat;
  logic             over;

  assign div_start = (state_q == ST_PREP);

  uf_divider #(.NUM_W(NUM_W), .DEN_W(WP_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(div_start),
    .num  ({max_q, {FRAC_BITS{1'b0}}}),
    .den  (min_q),
    .quo  (quo),
    .done (div_done)
  );

  assign unf_sat = (|quo[NUM_W-1:UF_W]) ? {UF_W{1'b1}} : quo[UF_W-1:0];
  assign over    = (unf_sat > tgt_q);

  // sequencing and registered decision
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      max_q      <= '0;
      min_q      <= '0;
      slow_q     <= '0;
      intf_q     <= '0;
      dec_valid  <= 1'b0;
      dec_slow   <= '0;
      dec_intf   <= '0;
      dec_down   <= 1'b0;
      dec_up     <= 1'b0;
      dec_unfair <= '0;
    end else begin
      dec_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (tick) state_q <= ST_RANK;
        ST_RANK: begin
          max_q   <= top_val;
          min_q   <= low_val;
          slow_q  <= top_idx;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          intf_q  <= pick_idx;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          dec_valid  <= 1'b1;
          dec_slow   <= slow_q;
          dec_intf   <= intf_q;
          dec_unfair <= unf_sat;
          dec_down   <= over;
          dec_up     <= over;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uf_eval_chk.sv
module uf_eval_chk #(
  parameter int ID_W         = 2,
  parameter int UF_W         = 16,
  parameter int INTERVAL_LEN = 256,
  parameter int LAT          = 35
) (
  input logic            clk,
  input logic            rst,
  input logic            dec_valid,
  input logic [ID_W-1:0] dec_slow,
  input logic [ID_W-1:0] dec_intf,
  input logic            dec_down,
  input logic            dec_up,
  input logic [UF_W-1:0] dec_unfair
);
  localparam int PW = $clog2(INTERVAL_LEN);

  // own phase counter, independent of the design's timer
  logic [PW-1:0] phase_q;
  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= (phase_q == PW'(INTERVAL_LEN-1)) ? '0 : phase_q + 1'b1;
  end

  p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  p_fixed_latency_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (phase_q == PW'(LAT)));

  p_flags_paired_r4: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_down == dec_up));

  p_not_self_r2: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_slow != dec_intf));

  p_ratio_floor_r3: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_unfair >= UF_W'(256)));

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!dec_valid && !dec_down && !dec_up));
endmodule

bind uf_eval uf_eval_chk #(
  .ID_W(ID_W), .UF_W(UF_W), .INTERVAL_LEN(INTERVAL_LEN), .LAT(LAT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dec_valid (dec_valid),
  .dec_slow  (dec_slow),
  .dec_intf  (dec_intf),
  .dec_down  (dec_down),
  .dec_up    (dec_up),
  .dec_unfair(dec_unfair)
);

// File: tb/sim_uf_eval.sv
`timescale 1ns/1ps
module sim_uf_eval;
  localparam int N    = 4;
  localparam int SD_W = 16;
  localparam int WT_W = 8;
  localparam int CW   = 6;
  localparam int UF_W = 16;
  localparam int LEN  = 200;
  localparam int LAT  = SD_W + WT_W + 11;
  localparam int NINT = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst;
  logic [N*SD_W-1:0] slowdown_in;
  logic [N*WT_W-1:0] weight_in;
  logic [UF_W-1:0]   target_in;
  logic              ev_valid;
  logic [1:0]        ev_victim, ev_culprit;
  logic              dec_valid, dec_down, dec_up;
  logic [1:0]        dec_slow, dec_intf;
  logic [UF_W-1:0]   dec_unfair;

  always #4 clk = ~clk;

  uf_eval #(.N_CORES(N), .SD_W(SD_W), .WT_W(WT_W), .CNT_W(CW), .UF_W(UF_W),
            .INTERVAL_LEN(LEN)) u0 (
    .clk(clk), .rst(rst), .slowdown_in(slowdown_in), .weight_in(weight_in),
    .target_in(target_in), .ev_valid(ev_valid), .ev_victim(ev_victim),
    .ev_culprit(ev_culprit), .dec_valid(dec_valid), .dec_slow(dec_slow),
    .dec_intf(dec_intf), .dec_down(dec_down), .dec_up(dec_up),
    .dec_unfair(dec_unfair));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  longint p_sd[N], p_wt[N], d_sd[N], d_wt[N];
  longint p_tgt, d_tgt;
  int     m[N][N];
  longint exp_unf;
  int     exp_slow, exp_intf, exp_k;
  bit     exp_over;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      slowdown_in[i*SD_W +: SD_W] = SD_W'(d_sd[i]);
      weight_in[i*WT_W +: WT_W]   = WT_W'(d_wt[i]);
    end
    target_in = UF_W'(d_tgt);
  end

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint ratio_of();
    longint hi, lo, w;
    hi = p_sd[0] * p_wt[0];
    lo = hi;
    for (int i = 1; i < N; i++) begin
      w = p_sd[i] * p_wt[i];
      if (w > hi) hi = w;
      if (w < lo) lo = w;
    end
    if (lo == 0) return 65535;
    w = (hi * 256) / lo;
    return (w > 65535) ? 65535 : w;
  endfunction

  function automatic void compute_exp();
    longint best, w;
    int found;
    best = -1; exp_slow = 0;
    for (int i = 0; i < N; i++) begin
      w = p_sd[i] * p_wt[i];
      if (w > best) begin best = w; exp_slow = i; end
    end
    found = 0; exp_intf = 0; best = 0;
    for (int j = 0; j < N; j++) begin
      if (j != exp_slow && (found == 0 || m[exp_slow][j] > best)) begin
        best = m[exp_slow][j]; exp_intf = j; found = 1;
      end
    end
    exp_unf  = ratio_of();
    exp_over = (exp_unf > p_tgt);
  endfunction

  task automatic plan(input int k);
    for (int i = 0; i < N; i++) begin
      p_sd[i] = 256 + ($urandom % 768);
      p_wt[i] = 1 + ($urandom % 16);
    end
    p_tgt = 256 + ($urandom % 600);
    case (k)
      1: begin for (int i = 0; i < N; i++) begin p_sd[i] = 300; p_wt[i] = 5; end p_tgt = 256; end
      2: begin p_wt[3] = 0; p_tgt = 65534; end
      3, 4: begin for (int i = 0; i < N; i++) begin p_sd[i] = 256; p_wt[i] = 4; end p_sd[2] = 900; end
      5, 6: begin for (int i = 0; i < N; i++) begin p_sd[i] = 256; p_wt[i] = 4; end p_sd[1] = 800; end
      8: p_tgt = ratio_of() - 1;
      9: p_tgt = ratio_of();
      10: begin
        for (int i = 0; i < N; i++) p_sd[i] = 400;
        p_wt[0] = 2; p_wt[1] = 7; p_wt[2] = 3; p_wt[3] = 7;
      end
      default: ;
    endcase
  endtask

  task automatic drive_edge(input int e);
    int ki, ph, v, c;
    bit val;
    int unsigned r;
    ki = e / LEN;
    ph = e % LEN;
    if (ph == 0) begin
      compute_exp();
      exp_k = ki - 1;
      for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) m[a][b] = 0;
    end
    r = $urandom;
    val = r[0]; v = int'(r[3:2]); c = int'(r[5:4]);
    case (ki)
      1, 2, 5: val = 0;
      3: begin val = (ph < 180); v = 2; c = (ph < 100) ? 3 : 1; end
      4: begin val = (ph < 150) || (ph == 160); v = 2; c = (ph == 160) ? 3 : 2; end
      6: begin val = (ph == 0); v = 1; c = 3; end
      default: ;
    endcase
    if (val && v != c && m[v][c] < CMAX) m[v][c]++;
    ev_valid = val; ev_victim = 2'(v); ev_culprit = 2'(c);
    // R7: garbage on the sampled inputs away from the boundary
    if (ki == 7 && ph >= 10 && ph <= LEN - 10) begin
      for (int i = 0; i < N; i++) begin d_sd[i] = $urandom % 65536; d_wt[i] = $urandom % 256; end
      d_tgt = $urandom % 65536;
    end else begin
      for (int i = 0; i < N; i++) begin d_sd[i] = p_sd[i]; d_wt[i] = p_wt[i]; end
      d_tgt = p_tgt;
    end
  endtask

  task automatic check_edge(input int n);
    string ti;
    if (n > LAT && ((n - LAT) % LEN) == 0) begin
      chk("R5 strobe", dec_valid == 1'b1, dec_valid, 1);
      if (exp_k == 7) begin
        chk("R7 slowest", dec_slow == 2'(exp_slow), dec_slow, exp_slow);
        chk("R7 ratio", dec_unfair == UF_W'(exp_unf), dec_unfair, exp_unf);
      end else begin
        chk("R1 slowest", dec_slow == 2'(exp_slow), dec_slow, exp_slow);
        chk("R3 ratio", dec_unfair == UF_W'(exp_unf), dec_unfair, exp_unf);
      end
      ti = (exp_k == 3 || exp_k == 4) ? "R6 interferer" :
           (exp_k == 5 || exp_k == 6) ? "R8 interferer" : "R2 interferer";
      chk(ti, dec_intf == 2'(exp_intf), dec_intf, exp_intf);
      chk("R4 down", dec_down == exp_over, dec_down, exp_over);
      chk("R4 up", dec_up == exp_over, dec_up, exp_over);
    end else begin
      chk("R5 quiet", dec_valid == 1'b0, dec_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    rst = 1'b1;
    ev_valid = 0; ev_victim = 0; ev_culprit = 0;
    for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) m[a][b] = 0;
    plan(0);
    for (int i = 0; i < N; i++) begin d_sd[i] = p_sd[i]; d_wt[i] = p_wt[i]; end
    d_tgt = p_tgt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 valid", dec_valid == 1'b0, dec_valid, 0);
    chk("R9 flags", {dec_down, dec_up} == 2'b00, {dec_down, dec_up}, 0);
    chk("R9 ids", {dec_slow, dec_intf} == 4'h0, {dec_slow, dec_intf}, 0);
    chk("R9 ratio", dec_unfair == '0, dec_unfair, 0);
    rst = 1'b0;
    drive_edge(1);
    for (int n = 1; n <= NINT * LEN + LAT + 2; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_edge(n);
      if (n % LEN == 0) plan(n / LEN);
      drive_edge(n + 1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(64'd200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule